// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Trap

This block is the integer execute stage of a 32-bit load-store processor. Each cycle it accepts one operation, selected by a 6-bit major opcode and, for register-register forms, a 6-bit function code. It takes two register operands, or one register operand and a 16-bit immediate. It computes add, subtract, OR, signed and unsigned set-less-than, or load-upper-immediate. One clock later it presents the 32-bit result, the destination register index and a write-enable for the register file.

The add and subtract forms come in a trapping (signed) flavour and a non-trapping (unsigned) flavour. Both flavours run on one shared adder. When a trapping form overflows in two's complement, the unit raises a one-cycle trap flag and drops the write-enable, so the destination keeps its old value. The immediate is sign-extended or zero-extended, and the opcode decides which. A write aimed at register 0 is always suppressed.

Top module: `exu_top`

## Requirements
- R1: After a synchronous reset, out_valid, out_we, out_trap, out_result and out_dst are all zero.
- R2: Outputs appear exactly one clock after the inputs are sampled, and out_valid equals the in_valid of that cycle.
- R3: The result is the 32-bit sum (modulo 2^32) for R-format function 32 (add) and 33 (add-unsigned), and for opcodes 8 (add-immediate) and 9 (add-immediate-unsigned). It is first operand minus second operand for function 34 (subtract) and 35 (subtract-unsigned).
- R4: When function 32, function 34 or opcode 8 produces a two's-complement overflow, out_trap is 1 and out_we is 0 for that operation. out_result still carries the wrapped value.
- R5: Functions 33 and 35 and opcode 9 never raise out_trap, whatever the operands.
- R6: The immediate is sign-extended for opcodes 8 and 10. It is zero-extended for opcodes 9, 11 and 13.
- R7: Function 42 and opcode 10 give 1 when the first operand is less than the second as signed numbers, and 0 otherwise. Function 43 and opcode 11 make the same comparison on unsigned values.
- R8: Function 37 and opcode 13 give the bitwise OR of the operands.
- R9: Opcode 15 gives the immediate in bits 31:16 and zeros in bits 15:0.
- R10: Opcode 0 writes the register named by in_rd_idx. Every other supported opcode writes the register named by in_rt_idx. When that index is 0, out_we is 0.
- R11: An unsupported opcode, or an unsupported function code under opcode 0, gives out_we=0, out_trap=0, out_result=0 and out_dst=0.
- R12: When in_valid is 0, the next cycle shows out_we=0, out_trap=0, out_result=0 and out_dst=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is present this cycle |
| in_opcode | input | 6 | Major opcode |
| in_funct | input | 6 | Function code for opcode 0 |
| in_rs_val | input | 32 | First register operand |
| in_rt_val | input | 32 | Second register operand |
| in_imm | input | 16 | Immediate constant |
| in_rt_idx | input | 5 | Destination index for immediate forms |
| in_rd_idx | input | 5 | Destination index for register forms |
| out_valid | output | 1 | Registered copy of in_valid |
| out_result | output | 32 | Computed result |
| out_we | output | 1 | Register-file write-enable |
| out_dst | output | 5 | Destination register index |
| out_trap | output | 1 | Signed-overflow exception |

## Verification
Random operand pairs are mixed with directed edge values: 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and zero. The edge values separate a correct overflow test from one that only looks at the carry, and a signed compare from an unsigned one. Immediates with bit 15 set separate sign extension from zero extension on each opcode. Trapping and non-trapping forms receive identical operands, which shows that only the trap and the write-enable differ between them. Destination index 0, unsupported codes and idle cycles confirm that no write leaks out.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'd9;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'd11;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

  localparam logic [FN_W-1:0] FN_ADD  = 6'd32;
  localparam logic [FN_W-1:0] FN_ADDU = 6'd33;
  localparam logic [FN_W-1:0] FN_SUB  = 6'd34;
  localparam logic [FN_W-1:0] FN_SUBU = 6'd35;
  localparam logic [FN_W-1:0] FN_OR   = 6'd37;
  localparam logic [FN_W-1:0] FN_SLT  = 6'd42;
  localparam logic [FN_W-1:0] FN_SLTU = 6'd43;

  typedef enum logic [2:0] {
    K_NONE, K_ADD, K_SUB, K_OR, K_SLT, K_SLTU, K_LUI
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  use_imm;
    logic  sext;
    logic  trap_en;
    logic  dst_is_rd;
  } ctl_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output ctl_t             ctl
);
  always_comb begin
    ctl = '{kind: K_NONE, use_imm: 1'b1, sext: 1'b0, trap_en: 1'b0, dst_is_rd: 1'b0};
    case (opcode)
      OPC_RTYPE: begin
        ctl.use_imm   = 1'b0;
        ctl.dst_is_rd = 1'b1;
        case (funct)
          FN_ADD:  begin ctl.kind = K_ADD; ctl.trap_en = 1'b1; end
          FN_ADDU: ctl.kind = K_ADD;
          FN_SUB:  begin ctl.kind = K_SUB; ctl.trap_en = 1'b1; end
          FN_SUBU: ctl.kind = K_SUB;
          FN_OR:   ctl.kind = K_OR;
          FN_SLT:  ctl.kind = K_SLT;
          FN_SLTU: ctl.kind = K_SLTU;
          default: ctl.kind = K_NONE;
        endcase
      end
      OPC_ADDI:  begin ctl.kind = K_ADD; ctl.sext = 1'b1; ctl.trap_en = 1'b1; end
      OPC_ADDIU: ctl.kind = K_ADD;
      OPC_SLTI:  begin ctl.kind = K_SLT; ctl.sext = 1'b1; end
      OPC_SLTIU: ctl.kind = K_SLTU;
      OPC_ORI:   ctl.kind = K_OR;
      OPC_LUI:   ctl.kind = K_LUI;
      default:   ctl.kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/exu_operand.sv
module exu_operand #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              sext,
  output logic [DATA_W-1:0] opb
);
  localparam int FILL_W = DATA_W - IMM_W;

  logic [FILL_W-1:0] fill;
  logic [DATA_W-1:0] imm_ext;

  assign fill    = sext ? {FILL_W{imm[IMM_W-1]}} : {FILL_W{1'b0}};
  assign imm_ext = {fill, imm};
  assign opb     = use_imm ? imm_ext : rt_val;
endmodule

// File: rtl/exu_arith.sv
module exu_arith
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  kind_e             kind,
  input  logic              trap_en,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              ovf
);
  localparam int MSB   = DATA_W - 1;
  localparam int LOW_W = DATA_W - IMM_W;

  logic              inv;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum_w;
  logic [DATA_W-1:0] sum;
  logic              carry;
  logic              lt_s, lt_u;

  // one adder serves add, subtract and both compares
  assign inv   = (kind != K_ADD);
  assign b_eff = inv ? ~b : b;
  assign sum_w = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, inv};
  assign sum   = sum_w[DATA_W-1:0];
  assign carry = sum_w[DATA_W];

  assign lt_s = (a[MSB] != b[MSB]) ? a[MSB] : sum[MSB];
  assign lt_u = ~carry;

  assign ovf = trap_en && (kind == K_ADD || kind == K_SUB)
               && (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

  always_comb begin
    case (kind)
      K_ADD, K_SUB: result = sum;
      K_OR:         result = a | b;
      K_SLT:        result = {{(DATA_W-1){1'b0}}, lt_s};
      K_SLTU:       result = {{(DATA_W-1){1'b0}}, lt_u};
      K_LUI:        result = {imm, {LOW_W{1'b0}}};
      default:      result = '0;
    endcase
  end
endmodule

// File: rtl/exu_top.sv
module exu_top
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [5:0]        in_opcode,
  input  logic [5:0]        in_funct,
  input  logic [DATA_W-1:0] in_rs_val,
  input  logic [DATA_W-1:0] in_rt_val,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [REG_AW-1:0] in_rt_idx,
  input  logic [REG_AW-1:0] in_rd_idx,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_we,
  output logic [REG_AW-1:0] out_dst,
  output logic              out_trap
);
  ctl_t              ctl;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] res;
  logic              ovf;
  logic              known;
  logic [REG_AW-1:0] dst;

  exu_decode u_dec (.opcode(in_opcode), .funct(in_funct), .ctl(ctl));

  exu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .rt_val(in_rt_val), .imm(in_imm), .use_imm(ctl.use_imm),
    .sext(ctl.sext), .opb(opb)
  );

  exu_arith #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_alu (
    .kind(ctl.kind), .trap_en(ctl.trap_en), .a(in_rs_val), .b(opb),
    .imm(in_imm), .result(res), .ovf(ovf)
  );

  assign known = in_valid && (ctl.kind != K_NONE);
  assign dst   = ctl.dst_is_rd ? in_rd_idx : in_rt_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_we     <= 1'b0;
      out_dst    <= '0;
      out_trap   <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      out_result <= known ? res : '0;
      out_dst    <= known ? dst : '0;
      out_trap   <= known && ovf;
      out_we     <= known && !ovf && (dst != '0);
    end
  end

  AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    out_trap |-> !out_we); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_we && !out_trap)); // R12
  AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (rst)
    out_we |-> (out_dst != '0)); // R10
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_UNSIGNED_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode == OPC_ADDIU) |=> !out_trap); // R5
  AST_SLT_IS_BIT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_opcode == OPC_SLTI || in_opcode == OPC_SLTIU))
      |=> (out_result[DATA_W-1:1] == '0)); // R7
  AST_LUI_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_opcode == OPC_LUI) |=> (out_result[DATA_W-IMM_W-1:0] == '0)); // R9
endmodule

// File: tb/exu_top_tb.sv
module exu_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [5:0]  in_opcode, in_funct;
  logic [31:0] in_rs_val, in_rt_val;
  logic [15:0] in_imm;
  logic [4:0]  in_rt_idx, in_rd_idx;
  logic        out_valid, out_we, out_trap;
  logic [31:0] out_result;
  logic [4:0]  out_dst;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  exu_top u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_funct(in_funct), .in_rs_val(in_rs_val), .in_rt_val(in_rt_val),
    .in_imm(in_imm), .in_rt_idx(in_rt_idx), .in_rd_idx(in_rd_idx),
    .out_valid(out_valid), .out_result(out_result), .out_we(out_we),
    .out_dst(out_dst), .out_trap(out_trap)
  );

  typedef struct packed {
    logic        vld;
    logic        we;
    logic        trap;
    logic [31:0] res;
    logic [4:0]  dst;
  } exp_t;

  function automatic logic sovf(input logic [31:0] a, input logic [31:0] b, input logic sub);
    longint s;
    s = sub ? (longint'($signed(a)) - longint'($signed(b)))
            : (longint'($signed(a)) + longint'($signed(b)));
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  function automatic exp_t model(input logic v, input logic [5:0] op, input logic [5:0] fn,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic [15:0] im, input logic [4:0] rt, input logic [4:0] rd);
    exp_t e;
    logic known, ov;
    logic [31:0] sx, zx, r;
    logic [4:0] d;
    sx = {{16{im[15]}}, im};
    zx = {16'h0, im};
    known = 1'b1; ov = 1'b0; r = '0;
    d = (op == 6'd0) ? rd : rt;
    case (op)
      6'd0: case (fn)
        6'd32: begin r = a + b; ov = sovf(a, b, 1'b0); end
        6'd33: r = a + b;
        6'd34: begin r = a - b; ov = sovf(a, b, 1'b1); end
        6'd35: r = a - b;
        6'd37: r = a | b;
        6'd42: r = {31'h0, $signed(a) < $signed(b)};
        6'd43: r = {31'h0, a < b};
        default: known = 1'b0;
      endcase
      6'd8:  begin r = a + sx; ov = sovf(a, sx, 1'b0); end
      6'd9:  r = a + zx;
      6'd10: r = {31'h0, $signed(a) < $signed(sx)};
      6'd11: r = {31'h0, a < zx};
      6'd13: r = a | zx;
      6'd15: r = {im, 16'h0};
      default: known = 1'b0;
    endcase
    e.vld = v;
    if (!v || !known) begin
      e.we = 1'b0; e.trap = 1'b0; e.res = '0; e.dst = '0;
    end else begin
      e.trap = ov; e.we = !ov && (d != 5'd0); e.res = r; e.dst = d;
    end
    return e;
  endfunction

  task automatic run(input logic v, input logic [5:0] op, input logic [5:0] fn,
                     input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                     input logic [4:0] rt, input logic [4:0] rd, input string tag);
    exp_t e, got;
    @(negedge clk);
    in_valid = v; in_opcode = op; in_funct = fn; in_rs_val = a; in_rt_val = b;
    in_imm = im; in_rt_idx = rt; in_rd_idx = rd;
    e = model(v, op, fn, a, b, im, rt, rd);
    @(posedge clk);
    #1;
    got = '{vld: out_valid, we: out_we, trap: out_trap, res: out_result, dst: out_dst};
    total++;
    if (got !== e) begin
      bad++;
      $display("FAIL %s op=%0d fn=%0d: got v=%b we=%b trap=%b res=%h dst=%0d exp v=%b we=%b trap=%b res=%h dst=%0d",
               tag, op, fn, got.vld, got.we, got.trap, got.res, got.dst,
               e.vld, e.we, e.trap, e.res, e.dst);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, got hung expected done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] ops [8];
    logic [5:0] fns [8];
    ops = '{6'd0, 6'd8, 6'd9, 6'd10, 6'd11, 6'd13, 6'd15, 6'd0};
    fns = '{6'd32, 6'd33, 6'd34, 6'd35, 6'd37, 6'd42, 6'd43, 6'd32};
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; in_opcode = '0; in_funct = '0;
    in_rs_val = '0; in_rt_val = '0; in_imm = '0; in_rt_idx = '0; in_rd_idx = '0;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if ({out_valid, out_we, out_trap, out_result, out_dst} !== '0) begin
      bad++;
      $display("FAIL R1 reset: got %b/%b/%b/%h/%0d expected all zero",
               out_valid, out_we, out_trap, out_result, out_dst);
    end
    @(negedge clk); rst = 1'b0;

    // R3 / R4 / R5 add and subtract corners
    run(1, 0, 32, 32'h7FFFFFFF, 32'h1, 0, 1, 3, "R4 add ovf");
    run(1, 0, 33, 32'h7FFFFFFF, 32'h1, 0, 1, 3, "R5 addu");
    run(1, 0, 32, 32'h80000000, 32'hFFFFFFFF, 0, 1, 4, "R4 add neg ovf");
    run(1, 0, 32, 32'hFFFFFFFF, 32'h1, 0, 1, 4, "R3 add carry no ovf");
    run(1, 0, 34, 32'h80000000, 32'h1, 0, 1, 5, "R4 sub ovf");
    run(1, 0, 35, 32'h80000000, 32'h1, 0, 1, 5, "R5 subu");
    run(1, 0, 34, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 1, 5, "R4 sub ovf pos");
    run(1, 0, 34, 32'h5, 32'h9, 0, 1, 6, "R3 sub");
    run(1, 8, 0, 32'h7FFFFFFF, 0, 16'h0001, 7, 0, "R4 addi ovf");
    run(1, 8, 0, 32'h10, 0, 16'hFFFF, 7, 0, "R6 addi sext");
    run(1, 9, 0, 32'h10, 0, 16'hFFFF, 7, 0, "R6 addiu zext");
    run(1, 9, 0, 32'hFFFFFFFF, 0, 16'hFFFF, 7, 0, "R5 addiu wrap");
    // R7 compares
    run(1, 0, 42, 32'hFFFFFFFF, 32'h1, 0, 1, 8, "R7 slt neg");
    run(1, 0, 43, 32'hFFFFFFFF, 32'h1, 0, 1, 8, "R7 sltu");
    run(1, 0, 42, 32'h3, 32'h3, 0, 1, 8, "R7 slt equal");
    run(1, 10, 0, 32'hFFFFFFFE, 0, 16'hFFFF, 9, 0, "R7 slti");
    run(1, 11, 0, 32'h0000FFFE, 0, 16'hFFFF, 9, 0, "R6 sltiu zext");
    run(1, 11, 0, 32'hFFFFFFFE, 0, 16'hFFFF, 9, 0, "R7 sltiu");
    // R8 / R9
    run(1, 0, 37, 32'hF0F00000, 32'h0000F0F0, 0, 1, 10, "R8 or");
    run(1, 13, 0, 32'h12340000, 0, 16'h8765, 11, 0, "R8 ori zext");
    run(1, 15, 0, 32'hFFFFFFFF, 0, 16'h1B23, 12, 0, "R9 lui");
    // R10 destination choice and register 0
    run(1, 0, 33, 32'h1, 32'h2, 0, 13, 0, "R10 rd zero");
    run(1, 9, 0, 32'h1, 0, 16'h2, 0, 14, "R10 rt zero");
    run(1, 9, 0, 32'h1, 0, 16'h2, 15, 0, "R10 rt chosen");
    // R11 unsupported codes
    run(1, 0, 36, 32'h1, 32'h2, 0, 1, 3, "R11 bad funct");
    run(1, 6'd63, 0, 32'h1, 32'h2, 16'h5, 1, 3, "R11 bad opcode");
    // R12 idle cycle with a trapping operation on the inputs
    run(0, 0, 32, 32'h7FFFFFFF, 32'h1, 0, 1, 3, "R12 idle");
    // R2 back to back
    run(1, 0, 33, 32'h11, 32'h22, 0, 1, 2, "R2 b2b a");
    run(1, 0, 35, 32'h11, 32'h22, 0, 1, 2, "R2 b2b b");

    for (int i = 0; i < 800; i++) begin
      int k;
      logic [31:0] a, b;
      k = int'($urandom_range(0, 7));
      a = $urandom;
      b = $urandom;
      if ($urandom_range(0, 3) == 0) a = {a[31], {31{~a[31]}}};
      run($urandom_range(0, 9) != 0,
          ($urandom_range(0, 19) == 0) ? 6'($urandom) : ops[k],
          ($urandom_range(0, 19) == 0) ? 6'($urandom) : fns[int'($urandom_range(0, 7))],
          a, b, 16'($urandom), 5'($urandom), 5'($urandom), "R3 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule